// File: doc/BRIEF.md
# 100BASE-TX Receive Code-Group Aligner and Decoder

This block accepts the serial bit stream that leaves a descrambler, one bit per assertion of a bit strobe, and rebuilds the receive side of a media-independent interface from it. While the line is idle it watches for the first zero that follows a long run of ones. It fixes the five-bit code-group boundary at that point and then checks that the first two code-groups form the start delimiter pair. A packet that opens correctly is passed to the MAC as two preamble nibbles followed by the decoded data nibbles. It closes on the end delimiter pair or on two idle code-groups.

Any other departure from idle is treated as a false carrier. Each code-group of such a burst is reported as a fixed error nibble with carrier sense asserted and data-valid low, until two idle code-groups arrive. Each burst adds one to a saturating event counter. Every output changes together with a one-cycle code-group strobe. Each nibble is reported one code-group late, because the decision on a code-group needs the code-group after it.

Top module: `rxcg_decoder`

## Requirements
- R1: After reset, nib_stb, rxd, rx_dv, rx_er and crs are 0 and fc_cnt is 0.
- R2: A start is recognised only at a zero that follows at least 10 consecutive ones (two idle code-groups). An earlier zero is ignored: it produces no strobe, crs stays 0 and fc_cnt is unchanged.
- R3: Bits arrive leftmost first. When the start delimiter pair 11000 10001 follows the idle run, the code-group boundary is fixed at it. The pair is reported as two strobes, each with rxd=0101, rx_dv=1, rx_er=0 and crs=1. rx_dv is never 1 while crs is 0.
- R4: Inside a packet, each data code-group is decoded to its nibble by the 4B5B table (for example 11110 to 0000, 11010 to 1100, 11101 to 1111, 10011 to 1001, 01111 to 0111, 10100 to 0010). It is reported with rx_dv=1 and rx_er=0, one code-group after it arrives.
- R5: The end delimiter pair 01101 00111 closes the packet with one strobe carrying rxd=0000 and rx_dv=rx_er=crs=0. No nibble is reported for the end delimiter.
- R6: Two consecutive idle code-groups (11111) inside a packet close it the same way as R5. The first idle produces no nibble.
- R7: An idle, start, end or other non-data code-group inside a packet (for example 00000 or 00100) is reported with rx_er=1, rx_dv=1 and rxd=1110.
- R8: When the two code-groups after the idle run are not the start delimiter pair, each code-group is reported with rxd=1110, rx_er=1, rx_dv=0 and crs=1. This continues until two idle code-groups are seen, which produce one strobe with rxd=0000 and rx_er=crs=0.
- R9: fc_cnt rises by exactly one for each false-carrier burst, at the first strobe of that burst, and holds at its all-ones value once reached.
- R10: nib_stb is a single-cycle pulse issued once per code-group. rxd, rx_dv, rx_er and crs change only together with it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | Strobe marking a valid received bit |
| bit_in | input | 1 | Received descrambled bit |
| nib_stb | output | 1 | One-cycle pulse per reported code-group |
| rxd | output | 4 | Receive nibble |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error |
| crs | output | 1 | Carrier sense |
| fc_cnt | output | CNT_W | Saturating false-carrier event count |

## Verification
Several rules are checked by the assertions on every cycle:
- carrier sense covers data-valid;
- the error nibble value goes with every error;
- the quiet closing strobe;
- the counter moves one step only at a false-carrier strobe and stays pinned at its maximum;
- outputs stay frozen between strobes.

Only the bench scenarios can show the following:
- the idle-arming threshold of ten ones;
- the boundary placement at the start delimiter;
- the table decode of each data code-group;
- the exact nibble sequence and strobe count of each packet or burst;
- the two different ways a packet closes.

// File: rtl/rxcg_pkg.sv
package rxcg_pkg;

  localparam int CG_W   = 5;
  localparam int WIN_W  = 2 * CG_W;
  localparam int NIB_W  = 4;
  // ones ahead of the first zero in the start code-group
  localparam int J_LEAD = 2;

  localparam logic [CG_W-1:0] CG_IDLE = 5'b11111;
  localparam logic [CG_W-1:0] CG_SD1  = 5'b11000;
  localparam logic [CG_W-1:0] CG_SD2  = 5'b10001;
  localparam logic [CG_W-1:0] CG_ED1  = 5'b01101;
  localparam logic [CG_W-1:0] CG_ED2  = 5'b00111;

  localparam logic [NIB_W-1:0] NIB_PRE = 4'b0101;
  localparam logic [NIB_W-1:0] NIB_BAD = 4'b1110;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_SSD1,
    ST_SSD2,
    ST_KPEND,
    ST_PKT,
    ST_FALSE
  } cg_state_e;

  // returns {valid, nibble}
  function automatic logic [NIB_W:0] cg_decode(input logic [CG_W-1:0] cg);
    logic [NIB_W:0] r;
    case (cg)
      5'b11110: r = 5'b1_0000;
      5'b01001: r = 5'b1_0001;
      5'b10100: r = 5'b1_0010;
      5'b10101: r = 5'b1_0011;
      5'b01010: r = 5'b1_0100;
      5'b01011: r = 5'b1_0101;
      5'b01110: r = 5'b1_0110;
      5'b01111: r = 5'b1_0111;
      5'b10010: r = 5'b1_1000;
      5'b10011: r = 5'b1_1001;
      5'b10110: r = 5'b1_1010;
      5'b10111: r = 5'b1_1011;
      5'b11010: r = 5'b1_1100;
      5'b11011: r = 5'b1_1101;
      5'b11100: r = 5'b1_1110;
      5'b11101: r = 5'b1_1111;
      default:  r = 5'b0_0000;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rxcg_shift.sv
module rxcg_shift #(
  parameter int WIN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             bit_in,
  output logic [WIN_W-1:0] win
);

  logic [WIN_W-2:0] hist_q;

  // newest bit sits at the LSB; the window includes the bit being accepted now
  assign win = {hist_q, bit_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else if (bit_en) begin
      hist_q <= win[WIN_W-2:0];
    end
  end

endmodule

// File: rtl/rxcg_fsm.sv
module rxcg_fsm
  import rxcg_pkg::*;
#(
  parameter int ARM_ONES = 2 * CG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             bit_in,
  input  logic [WIN_W-1:0] win,
  output logic             nib_stb,
  output logic [NIB_W-1:0] rxd,
  output logic             rx_dv,
  output logic             rx_er,
  output logic             crs,
  output logic             fc_evt
);

  localparam int RUN_W = $clog2(ARM_ONES + 1);
  localparam int PH_W  = $clog2(CG_W);
  localparam logic [RUN_W-1:0] RUN_MAX    = RUN_W'(ARM_ONES);
  localparam logic [PH_W-1:0]  PH_LAST    = PH_W'(CG_W - 1);
  localparam logic [PH_W-1:0]  PH_AFTER_Z = PH_W'(J_LEAD + 1);

  cg_state_e        st_q, st_d;
  logic [PH_W-1:0]  ph_q, ph_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic             stb_q, stb_d;
  logic [NIB_W-1:0] nib_q, nib_d;
  logic             dv_q, dv_d;
  logic             er_q, er_d;
  logic             crs_q, crs_d;
  logic             grp_done;
  logic [NIB_W:0]   dec;
  logic             is_sd, is_ed, is_ii;

  assign dec   = cg_decode(win[WIN_W-1 -: CG_W]);
  assign is_sd = (win == {CG_SD1, CG_SD2});
  assign is_ed = (win == {CG_ED1, CG_ED2});
  assign is_ii = (win == {CG_IDLE, CG_IDLE});

  always_comb begin
    st_d     = st_q;
    ph_d     = ph_q;
    run_d    = run_q;
    stb_d    = 1'b0;
    nib_d    = nib_q;
    dv_d     = dv_q;
    er_d     = er_q;
    crs_d    = crs_q;
    fc_evt   = 1'b0;
    grp_done = 1'b0;

    if (bit_en) begin
      if (st_q == ST_HUNT) begin
        if (bit_in) begin
          if (run_q != RUN_MAX) run_d = run_q + 1'b1;
        end else begin
          run_d = '0;
          if (run_q == RUN_MAX) begin
            st_d = ST_SSD1;
            ph_d = PH_AFTER_Z;
          end
        end
      end else if (ph_q == PH_LAST) begin
        ph_d     = '0;
        grp_done = 1'b1;
      end else begin
        ph_d = ph_q + 1'b1;
      end
    end

    if (grp_done) begin
      case (st_q)
        ST_SSD1: st_d = ST_SSD2;
        ST_SSD2: begin
          stb_d = 1'b1;
          crs_d = 1'b1;
          if (is_sd) begin
            nib_d = NIB_PRE;
            dv_d  = 1'b1;
            er_d  = 1'b0;
            st_d  = ST_KPEND;
          end else begin
            nib_d  = NIB_BAD;
            dv_d   = 1'b0;
            er_d   = 1'b1;
            fc_evt = 1'b1;
            st_d   = ST_FALSE;
          end
        end
        ST_KPEND: begin
          stb_d = 1'b1;
          nib_d = NIB_PRE;
          dv_d  = 1'b1;
          er_d  = 1'b0;
          crs_d = 1'b1;
          st_d  = ST_PKT;
        end
        ST_PKT: begin
          stb_d = 1'b1;
          if (is_ed || is_ii) begin
            nib_d = '0;
            dv_d  = 1'b0;
            er_d  = 1'b0;
            crs_d = 1'b0;
            st_d  = ST_HUNT;
          end else begin
            nib_d = dec[NIB_W] ? dec[NIB_W-1:0] : NIB_BAD;
            dv_d  = 1'b1;
            er_d  = ~dec[NIB_W];
            crs_d = 1'b1;
          end
        end
        ST_FALSE: begin
          stb_d = 1'b1;
          if (is_ii) begin
            nib_d = '0;
            er_d  = 1'b0;
            crs_d = 1'b0;
            st_d  = ST_HUNT;
          end else begin
            nib_d = NIB_BAD;
            er_d  = 1'b1;
            crs_d = 1'b1;
          end
          dv_d = 1'b0;
        end
        default: st_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_HUNT;
      ph_q  <= '0;
      run_q <= '0;
      stb_q <= 1'b0;
      nib_q <= '0;
      dv_q  <= 1'b0;
      er_q  <= 1'b0;
      crs_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ph_q  <= ph_d;
      run_q <= run_d;
      stb_q <= stb_d;
      nib_q <= nib_d;
      dv_q  <= dv_d;
      er_q  <= er_d;
      crs_q <= crs_d;
    end
  end

  assign nib_stb = stb_q;
  assign rxd     = nib_q;
  assign rx_dv   = dv_q;
  assign rx_er   = er_q;
  assign crs     = crs_q;

endmodule

// File: rtl/rxcg_fccnt.sv
module rxcg_fccnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (inc && (cnt_q != CNT_MAX)) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/rxcg_decoder.sv
module rxcg_decoder
  import rxcg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             bit_in,
  output logic             nib_stb,
  output logic [NIB_W-1:0] rxd,
  output logic             rx_dv,
  output logic             rx_er,
  output logic             crs,
  output logic [CNT_W-1:0] fc_cnt
);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [WIN_W-1:0] win;
  logic             fc_evt;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rxcg_shift #(.WIN_W(WIN_W)) shift_i (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .bit_en (bit_en),
    .bit_in (bit_in),
    .win    (win)
  );

  rxcg_fsm #(.ARM_ONES(2 * CG_W)) fsm_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .bit_en  (bit_en),
    .bit_in  (bit_in),
    .win     (win),
    .nib_stb (nib_stb),
    .rxd     (rxd),
    .rx_dv   (rx_dv),
    .rx_er   (rx_er),
    .crs     (crs),
    .fc_evt  (fc_evt)
  );

  rxcg_fccnt #(.W(CNT_W)) cnt_i (
    .clk   (clk),
    .rst_n (rst_int_n),
    .inc   (fc_evt),
    .cnt   (fc_cnt)
  );

endmodule

// File: rtl/rxcg_decoder_chk.sv
module rxcg_decoder_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_en,
  input logic             nib_stb,
  input logic [3:0]       rxd,
  input logic             rx_dv,
  input logic             rx_er,
  input logic             crs,
  input logic [CNT_W-1:0] fc_cnt
);

  localparam logic [CNT_W-1:0] FC_MAX = {CNT_W{1'b1}};

  assert_dv_under_crs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dv |-> crs);

  assert_err_nibble_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_er && rx_dv) |-> (rxd == 4'b1110));

  assert_false_carrier_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_er && !rx_dv) |-> ((rxd == 4'b1110) && crs));

  assert_quiet_close_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_stb && !crs) |-> (!rx_dv && !rx_er && (rxd == 4'b0000)));

  assert_cnt_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_cnt != $past(fc_cnt)) |->
      ((fc_cnt == ($past(fc_cnt) + 1'b1)) && nib_stb && rx_er && !rx_dv));

  assert_cnt_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fc_cnt) == FC_MAX) |-> (fc_cnt == FC_MAX));

  assert_stb_after_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    nib_stb |-> $past(bit_en));

  assert_hold_between_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !nib_stb |-> ($stable(rxd) && $stable(rx_dv) && $stable(rx_er) && $stable(crs)));

endmodule

bind rxcg_decoder rxcg_decoder_chk #(.CNT_W(CNT_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .bit_en  (bit_en),
  .nib_stb (nib_stb),
  .rxd     (rxd),
  .rx_dv   (rx_dv),
  .rx_er   (rx_er),
  .crs     (crs),
  .fc_cnt  (fc_cnt)
);

// File: tb/rxcg_decoder_tb_top.sv
module rxcg_decoder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 4;

  localparam logic [4:0] G_I  = 5'b11111;
  localparam logic [4:0] G_J  = 5'b11000;
  localparam logic [4:0] G_K  = 5'b10001;
  localparam logic [4:0] G_T  = 5'b01101;
  localparam logic [4:0] G_R  = 5'b00111;
  localparam logic [4:0] G_H  = 5'b00100;
  localparam logic [4:0] G_V0 = 5'b00000;

  logic             clk, rst_n, bit_en, bit_in;
  logic             nib_stb, rx_dv, rx_er, crs;
  logic [3:0]       rxd;
  logic [CNT_W-1:0] fc_cnt;

  int         total, bad, rec_n;
  logic [6:0] rec [0:31];

  rxcg_decoder #(.CNT_W(CNT_W)) dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_en  (bit_en),
    .bit_in  (bit_in),
    .nib_stb (nib_stb),
    .rxd     (rxd),
    .rx_dv   (rx_dv),
    .rx_er   (rx_er),
    .crs     (crs),
    .fc_cnt  (fc_cnt)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // record {crs, er, dv, nibble} for every strobe
  always @(negedge clk) begin
    if (rst_n && nib_stb) begin
      if (rec_n < 32) rec[rec_n] = {crs, rx_er, rx_dv, rxd};
      rec_n = rec_n + 1;
    end
  end

  function automatic logic [6:0] mk(input logic c, input logic e, input logic v,
                                    input logic [3:0] n);
    return {c, e, v, n};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_rec(input string req, input int idx, input logic [6:0] exp);
    check(req, (idx < rec_n && idx < 32) ? int'(rec[idx]) : -1, int'(exp));
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_en = 1'b1;
    bit_in = b;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic send_cg(input logic [4:0] cg);
    for (int i = 4; i >= 0; i--) send_bit(cg[i]);
  endtask

  task automatic send_idles(input int n);
    for (int i = 0; i < n; i++) send_cg(G_I);
  endtask

  task automatic t_reset();
    rst_n  = 1'b0;
    bit_en = 1'b0;
    bit_in = 1'b0;
    rec_n  = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 nib_stb", int'(nib_stb), 0);
    check("R1 rxd", int'(rxd), 0);
    check("R1 rx_dv", int'(rx_dv), 0);
    check("R1 rx_er", int'(rx_er), 0);
    check("R1 crs", int'(crs), 0);
    check("R1 fc_cnt", int'(fc_cnt), 0);
  endtask

  task automatic t_noise();
    rec_n = 0;
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    send_bit(1'b0);
    for (int i = 0; i < 9; i++) send_bit(1'b1);
    send_bit(1'b0);
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    check("R2 no strobe before arming", rec_n, 0);
    check("R2 crs idle", int'(crs), 0);
    check("R2 fc_cnt unchanged", int'(fc_cnt), 0);
  endtask

  task automatic t_pkt_end_delim();
    rec_n = 0;
    send_idles(3);
    send_cg(G_J); send_cg(G_K);
    send_cg(5'b11110); send_cg(5'b11010); send_cg(5'b11101);
    send_cg(G_T); send_cg(G_R);
    send_idles(3);
    check("R10 strobe count", rec_n, 6);
    check_rec("R3 first preamble", 0, mk(1, 0, 1, 4'b0101));
    check_rec("R3 second preamble", 1, mk(1, 0, 1, 4'b0101));
    check_rec("R4 data 0", 2, mk(1, 0, 1, 4'b0000));
    check_rec("R4 data C", 3, mk(1, 0, 1, 4'b1100));
    check_rec("R4 data F", 4, mk(1, 0, 1, 4'b1111));
    check_rec("R5 close on end delimiter", 5, mk(0, 0, 0, 4'b0000));
  endtask

  task automatic t_pkt_two_idles();
    rec_n = 0;
    send_idles(3);
    send_cg(G_J); send_cg(G_K);
    send_cg(5'b10011);
    send_idles(5);
    check("R10 strobe count", rec_n, 4);
    check_rec("R3 preamble", 1, mk(1, 0, 1, 4'b0101));
    check_rec("R4 data 9", 2, mk(1, 0, 1, 4'b1001));
    check_rec("R6 close on two idles", 3, mk(0, 0, 0, 4'b0000));
  endtask

  task automatic t_pkt_bad_codes();
    rec_n = 0;
    send_idles(3);
    send_cg(G_J); send_cg(G_K);
    send_cg(G_V0); send_cg(G_I); send_cg(5'b01111);
    send_cg(G_H); send_cg(5'b10100);
    send_cg(G_T); send_cg(G_R);
    send_idles(3);
    check("R10 strobe count", rec_n, 8);
    check_rec("R7 invalid 00000", 2, mk(1, 1, 1, 4'b1110));
    check_rec("R7 lone idle in data", 3, mk(1, 1, 1, 4'b1110));
    check_rec("R4 data 7", 4, mk(1, 0, 1, 4'b0111));
    check_rec("R7 halt code", 5, mk(1, 1, 1, 4'b1110));
    check_rec("R4 data 2", 6, mk(1, 0, 1, 4'b0010));
    check_rec("R5 close", 7, mk(0, 0, 0, 4'b0000));
    check("R9 no count on good packets", int'(fc_cnt), 0);
  endtask

  task automatic t_false_carrier();
    rec_n = 0;
    send_idles(3);
    send_cg(5'b11011); send_cg(5'b01010);
    send_idles(4);
    check("R8 strobe count", rec_n, 3);
    check_rec("R8 first bad group", 0, mk(1, 1, 0, 4'b1110));
    check_rec("R8 second bad group", 1, mk(1, 1, 0, 4'b1110));
    check_rec("R8 release on two idles", 2, mk(0, 0, 0, 4'b0000));
    check("R9 count after first burst", int'(fc_cnt), 1);
    // start code-group followed by a non-second-delimiter group
    rec_n = 0;
    send_idles(3);
    send_cg(G_J); send_cg(5'b01010);
    send_idles(4);
    check("R8 strobe count J then data", rec_n, 3);
    check_rec("R8 broken delimiter pair", 0, mk(1, 1, 0, 4'b1110));
    check("R9 count after second burst", int'(fc_cnt), 2);
  endtask

  task automatic short_burst();
    send_idles(3);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    send_idles(3);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 13; i++) short_burst();
    check("R9 count reaches max", int'(fc_cnt), 15);
    rec_n = 0;
    short_burst();
    check("R9 count holds at max", int'(fc_cnt), 15);
    check("R8 burst still reported", rec_n, 2);
    check_rec("R8 burst nibble", 0, mk(1, 1, 0, 4'b1110));
  endtask

  initial begin
    total = 0;
    bad   = 0;
    t_reset();
    t_noise();
    t_pkt_end_delim();
    t_pkt_two_idles();
    t_pkt_bad_codes();
    t_false_carrier();
    t_saturate();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule